// File: doc/BRIEF.md
# SPI Serial Clock Divider

This block sets the pace of a serial clock from the core clock. A configuration field, written by software, selects a divide ratio. The block emits a one-cycle pulse at every half period of the serial clock. A shift engine toggles the serial clock and moves data on each pulse. A level output shows which half of the period is running, so a downstream shifter can tell leading edges from trailing edges.

A parameter selects one of two field encodings. In the extended encoding the ratio is a 4-bit mantissa times a power of two, and the 3-bit exponent is spread over non-adjacent field bits. In the legacy encoding a 5-bit field holds half the ratio on top of a fixed marker bit, which gives even ratios from 4 to 30. A second parameter sets the smallest ratio the attached hardware can run at. Any smaller request is raised to that floor.

Top module: `sclk_divider`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `half_tick` and `sclk_phase` are 0.
- R2: With the extended encoding, the mantissa is `div_field[3:0]` and the exponent is {`div_field[7]`, `div_field[6]`, `div_field[4]`}, most significant first. The ratio is mantissa × 2^exponent, which tops out at 1920.
- R3: Field bits outside the selected encoding have no effect on the tick timing. Those bits are bit 5 for extended, and bits 7:5 for legacy.
- R4: With the extended encoding, a mantissa of 0 or 1 counts as 2 before the exponent is applied.
- R5: With the legacy encoding, the ratio is 2 × `div_field[3:0]` when `div_field[4]` is 1 and `div_field[3:0]` is at least 2. Every other legacy value gives a ratio of 4.
- R6: A decoded ratio below `MIN_RATIO` is raised to `MIN_RATIO`.
- R7: While running at ratio N, ticks alternate between gaps of N − ⌊N/2⌋ and ⌊N/2⌋ core cycles, and the longer gap comes first after a start. `sclk_phase` flips on every tick, so the duty cycle is exactly 50% for even N.
- R8: While `run_en` is 0, no tick is produced, `sclk_phase` is 0, and the half-period count restarts.
- R9: When the decoded ratio changes while running, the count restarts in that cycle with `sclk_phase` 0 and no tick. The first tick then follows after the longer half of the new ratio.
- R10: A field write that leaves the decoded ratio unchanged does not disturb the tick sequence or the phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Divider runs while 1 |
| div_field | input | 8 | Prescale field from the configuration register |
| half_tick | output | 1 | One-cycle pulse at each serial-clock half period |
| sclk_phase | output | 1 | 0 during the leading half, 1 during the trailing half |

## Verification
The embedded assertions check the following on every cycle:
- the outputs stay quiet while the divider is stopped;
- a ratio change yields a silent restart with the phase at 0;
- the phase flips with every tick;
- the half-period count stays below its limit;
- the decoded ratio never falls under the floor.

Only the bench scenarios can show that the exact gap lengths follow from a field value. This covers the split exponent, the mantissa substitution, the legacy marker bit, odd ratios and the raised floor of a stricter variant. The scenarios also show that writes which leave the ratio unchanged keep the sequence going without a hiccup.

// File: rtl/spi_div_pkg.sv
package spi_div_pkg;

  // Field encoding chosen at build time
  typedef enum logic {
    ENC_LEGACY   = 1'b0,
    ENC_EXTENDED = 1'b1
  } enc_e;

  // Widths of the extended encoding; bit placement depends on them
  localparam int MANT_W = 4;
  localparam int EXP_W  = 3;

  // Largest ratio the extended field can express
  localparam int MAX_RATIO = ((1 << MANT_W) - 1) << ((1 << EXP_W) - 1);

endpackage

// File: rtl/sclk_ratio_decode.sv
module sclk_ratio_decode
  import spi_div_pkg::*;
#(
  parameter enc_e ENCODING  = ENC_EXTENDED,
  parameter int   FIELD_W   = 8,
  parameter int   MIN_RATIO = 4,
  parameter int   RATIO_W   = 11
) (
  input  logic [FIELD_W-1:0] field,
  output logic [RATIO_W-1:0] ratio
);

  localparam logic [RATIO_W-1:0] MIN_R = RATIO_W'(MIN_RATIO);

  logic [RATIO_W-1:0] raw;

  generate
    if (ENCODING == ENC_EXTENDED) begin : g_ext
      logic [MANT_W-1:0]  mant;
      logic [EXP_W-1:0]   expo;
      logic [RATIO_W-1:0] base;
      logic               unused_ext;

      // Exponent bits straddle bit 5, which belongs to something else
      assign mant       = field[3:0];
      assign expo       = {field[7:6], field[4]};
      assign unused_ext = ^{1'b0, field[5]};

      always_comb begin
        if (mant < MANT_W'(2)) begin
          base = RATIO_W'(2);
        end else begin
          base = RATIO_W'(mant);
        end
        raw = base << expo;
      end
    end else begin : g_leg
      logic [3:0] half;
      logic       unused_leg;

      assign half       = field[3:0];
      assign unused_leg = ^{1'b0, field[7:5]};

      always_comb begin
        if (field[4] && (half >= 4'd2)) begin
          raw = RATIO_W'({half, 1'b0});
        end else begin
          raw = RATIO_W'(4);
        end
      end
    end
  endgenerate

  always_comb begin
    if (raw < MIN_R) begin
      ratio = MIN_R;
    end else begin
      ratio = raw;
    end
  end

endmodule

// File: rtl/sclk_half_timer.sv
module sclk_half_timer #(
  parameter int RATIO_W   = 11,
  parameter int MIN_RATIO = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [RATIO_W-1:0] ratio_in,
  output logic               tick_o,
  output logic               phase_o
);

  logic [RATIO_W-1:0] ratio_q, ratio_d;
  logic [RATIO_W-1:0] cnt_q, cnt_d;
  logic               phase_q, phase_d;
  logic               tick_q, tick_d;
  logic [RATIO_W-1:0] lead_len, trail_len, half_len;
  logic               reload;

  // Leading half takes the extra cycle of an odd ratio
  assign trail_len = ratio_q >> 1;
  assign lead_len  = ratio_q - trail_len;
  assign half_len  = phase_q ? trail_len : lead_len;
  assign reload    = !enable || (ratio_in != ratio_q);

  always_comb begin
    ratio_d = ratio_q;
    cnt_d   = cnt_q;
    phase_d = phase_q;
    tick_d  = 1'b0;
    if (reload) begin
      ratio_d = ratio_in;
      cnt_d   = '0;
      phase_d = 1'b0;
    end else if (cnt_q == half_len - RATIO_W'(1)) begin
      cnt_d   = '0;
      phase_d = !phase_q;
      tick_d  = 1'b1;
    end else begin
      cnt_d   = cnt_q + RATIO_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_q <= '0;
      cnt_q   <= '0;
      phase_q <= 1'b0;
      tick_q  <= 1'b0;
    end else begin
      ratio_q <= ratio_d;
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
      tick_q  <= tick_d;
    end
  end

  assign tick_o  = tick_q;
  assign phase_o = phase_q;

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!tick_o && !phase_o));

  // R9
  reload_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_in != ratio_q) |=> (!tick_o && !phase_o));

  // R7
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> (phase_o != $past(phase_o)));

  // R7
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enable && (ratio_in == ratio_q) |-> (cnt_q < half_len));

  // R6
  ratio_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_in >= RATIO_W'(MIN_RATIO));

endmodule

// File: rtl/sclk_divider.sv
module sclk_divider
  import spi_div_pkg::*;
#(
  parameter enc_e ENCODING  = ENC_EXTENDED,
  parameter int   FIELD_W   = 8,
  parameter int   MIN_RATIO = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_en,
  input  logic [FIELD_W-1:0] div_field,
  output logic               half_tick,
  output logic               sclk_phase
);

  localparam int RATIO_W = $clog2(MAX_RATIO + 1);

  logic [RATIO_W-1:0] ratio;

  sclk_ratio_decode #(
    .ENCODING (ENCODING),
    .FIELD_W  (FIELD_W),
    .MIN_RATIO(MIN_RATIO),
    .RATIO_W  (RATIO_W)
  ) u_decode (
    .field(div_field),
    .ratio(ratio)
  );

  sclk_half_timer #(
    .RATIO_W  (RATIO_W),
    .MIN_RATIO(MIN_RATIO)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (run_en),
    .ratio_in(ratio),
    .tick_o  (half_tick),
    .phase_o (sclk_phase)
  );

endmodule

// File: tb/sclk_divider_test.sv
module sclk_divider_test;
  import spi_div_pkg::*;

  localparam int LANES = 3;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [LANES-1:0] en;
  logic [7:0]       fld [LANES];
  logic [LANES-1:0] tick;
  logic [LANES-1:0] ph;

  int    errs   = 0;
  int    checks = 0;
  int    q [LANES][$];
  string tag [LANES];

  always #2 clk = ~clk;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Lane 0: extended floor 4, lane 1: legacy floor 4, lane 2: extended floor 15
  function automatic int exp_ratio(int ln, logic [7:0] f);
    int r, lo, e, m, fl;
    fl = (ln == 2) ? 15 : 4;
    lo = int'(f) % 16;
    if (ln == 1) begin
      r = (f[4] && lo >= 2) ? 2 * lo : 4;
    end else begin
      e = int'(f[4]) + 2 * int'(f[6]) + 4 * int'(f[7]);
      m = (lo < 2) ? 2 : lo;
      r = m * (1 << e);
    end
    if (r < fl) r = fl;
    return r;
  endfunction

  for (genvar g = 0; g < LANES; g++) begin : lane
    sclk_divider #(
      .ENCODING ((g == 1) ? ENC_LEGACY : ENC_EXTENDED),
      .MIN_RATIO((g == 2) ? 15 : 4)
    ) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_en    (en[g]),
      .div_field (fld[g]),
      .half_tick (tick[g]),
      .sclk_phase(ph[g])
    );

    int   gap    = 0;
    int   prev_r = -1;
    logic exp_ph = 1'b0;

    // Monitor: measures tick gaps and pops expected gaps
    always @(negedge clk) begin
      int er;
      if (rst_n) begin
        er = exp_ratio(g, fld[g]);
        if (!en[g]) begin
          gap = 0;
          exp_ph = 1'b0;
          if (tick[g]) chk(1'b0, "R8", "tick while stopped", 1, 0);
        end else if (er != prev_r) begin
          gap = 0;
          exp_ph = 1'b0;
          chk(tick[g] == 1'b0, "R9", "tick on reload", int'(tick[g]), 0);
        end else begin
          gap++;
          if (tick[g]) begin
            exp_ph = ~exp_ph;
            if (q[g].size() == 0) begin
              chk(1'b0, tag[g], "unexpected tick", gap, 0);
            end else begin
              int e;
              e = q[g].pop_front();
              chk(gap == e, tag[g], "tick gap", gap, e);
            end
            gap = 0;
          end
        end
        chk(ph[g] == exp_ph, en[g] ? tag[g] : "R8", "phase", int'(ph[g]), int'(exp_ph));
        prev_r = er;
      end
    end
  end

  // mode 0: start from stopped, 1: reload while running, 2: continue
  task automatic run(int ln, logic [7:0] f, int nt, string t, int mode,
                     bit first_trail, bit keep);
    int r, h1, h2, tot;
    r   = exp_ratio(ln, f);
    h2  = r / 2;
    h1  = r - h2;
    tot = 0;
    tag[ln] = t;
    fld[ln] = f;
    if (mode == 0) begin
      @(negedge clk);
      #1;
    end
    for (int k = 0; k < nt; k++) begin
      int len;
      len = (((k + int'(first_trail)) % 2) == 0) ? h1 : h2;
      q[ln].push_back(len);
      tot += len;
    end
    if (mode == 0) en[ln] = 1'b1;
    if (mode == 1) @(negedge clk);
    repeat (tot) @(negedge clk);
    #1;
    if (!keep) begin
      en[ln] = 1'b0;
      chk(q[ln].size() == 0, t, "ticks missing", q[ln].size(), 0);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "R7", "watchdog expired", 0, 1);
    report();
  end

  initial begin
    rst_n = 1'b0;
    en    = '0;
    for (int i = 0; i < LANES; i++) fld[i] = 8'h00;
    repeat (3) @(negedge clk);
    for (int i = 0; i < LANES; i++) begin
      chk(tick[i] == 1'b0 && ph[i] == 1'b0, "R1", "outputs in reset",
          int'({tick[i], ph[i]}), 0);
    end
    #1 rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < LANES; i++) begin
      chk(tick[i] == 1'b0 && ph[i] == 1'b0, "R1", "outputs after reset",
          int'({tick[i], ph[i]}), 0);
    end
    #1;
    // Extended encoding, split exponent
    run(0, 8'h13, 4, "R2", 0, 0, 0);
    run(0, 8'h43, 4, "R2", 0, 0, 0);
    run(0, 8'h83, 2, "R2", 0, 0, 0);
    run(0, 8'hDF, 2, "R2", 0, 0, 0);
    // Mantissa substitution
    run(0, 8'h50, 4, "R4", 0, 0, 0);
    run(0, 8'h51, 2, "R4", 0, 0, 0);
    // Floor
    run(0, 8'h01, 4, "R6", 0, 0, 0);
    // Odd ratio alternation
    run(0, 8'h0F, 5, "R7", 0, 0, 0);
    // Same-ratio rewrites, then a real change
    run(0, 8'h16, 3, "R10", 0, 0, 1);
    run(0, 8'h36, 3, "R3", 2, 1, 1);
    run(0, 8'h0C, 2, "R10", 2, 0, 1);
    run(0, 8'h07, 4, "R9", 1, 0, 0);
    // Stopped: nothing moves
    tag[0] = "R8";
    fld[0] = 8'h13;
    repeat (30) @(negedge clk);
    #1;
    // Legacy encoding
    run(1, 8'h1F, 2, "R5", 0, 0, 0);
    run(1, 8'h12, 4, "R5", 0, 0, 0);
    run(1, 8'h0A, 4, "R5", 0, 0, 0);
    run(1, 8'hF7, 4, "R3", 0, 0, 0);
    // Stricter floor
    run(2, 8'h04, 5, "R6", 0, 0, 0);
    run(2, 8'h19, 4, "R6", 0, 0, 0);
    run(2, 8'h00, 3, "R6", 0, 0, 0);
    repeat (5) @(negedge clk);
    report();
  end

endmodule